// File: doc/BRIEF.md
# A/D Conversion Sequencer

This block sequences a 10-bit successive-approximation converter for a small processor subsystem. It holds the converter's control state: an enable, a busy/start bit, a 2-bit conversion clock source, an interrupt enable and an interrupt flag. It presents a trial code to an external comparator and builds the result one bit per conversion period, most significant bit first. Software starts a conversion through a single-cycle register write. A compare-match event from a timer/capture unit can also start one.

The core's sleep signal changes what happens to a conversion in progress. With the internal RC clock selected, a started conversion first waits a short fixed delay, so that the core can go to sleep before any bit is decided. It then keeps running through sleep and, when the interrupt is enabled, ends with a wake request. With any divided system clock selected, sleep aborts the conversion and powers the converter down. The enable bit is not cleared. A compare-match event in the trigger mode also pulses a clear to a companion timer, whether or not the converter is enabled.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `go_busy`, `enabled`, `int_flag`, `wake_req`, `conv_powered` and `timer_clear` are 0, and `trial_code` is 0.
- R2: A write with `wr_en`=1 and `wr_go`=1 while idle starts a conversion (`go_busy`=1 after that clock edge). A write with `wr_go`=1 and `wr_en`=0 starts nothing.
- R3: The result is found by binary search. In the first conversion period `trial_code` is 10'h200. Each later trial keeps the already decided bits and sets the next lower bit. A decided bit takes the value of `cmp_in` (1 = input at or above the trial). The final result equals the largest code for which `cmp_in` stays 1.
- R4: `wr_src` values 2'b00, 2'b01 and 2'b10 make the conversion period 2, 8 and 32 system clocks. A conversion lasts 12 periods, so `go_busy` falls exactly 24, 96 or 384 clocks after the starting edge.
- R5: With `wr_src`=2'b11 (RC), a start first waits 4 system clocks. After that, each cycle with `rc_tick`=1 is one conversion period. With `rc_tick` held high, `go_busy` falls 16 clocks after the starting edge.
- R6: On completion, `go_busy` clears, `result` is loaded and `int_flag` sets, all on the same edge.
- R7: `int_flag` sets on every completion, whatever `wr_ie` holds. Only a write with `wr_flag`=0 clears it; writing 1 does not set it.
- R8: If a conversion completes while `core_sleep`=1 with the RC source, `wake_req` pulses for one cycle when the interrupt enable is 1. When the interrupt enable is 0, `conv_powered` drops to 0 instead. In both cases `enabled` stays 1.
- R9: `core_sleep`=1 with a non-RC source aborts a running conversion on the next edge. `conv_powered` drops to 0, `enabled` stays 1 and `result` is unchanged.
- R10: A write with `wr_go`=0 during a conversion aborts it on that edge and leaves `result` unchanged.
- R11: A `trig_in` pulse with `trig_mode`=4'b1011 starts a conversion when enabled and idle, and always gives a one-cycle `timer_clear` on the next edge, even when disabled. With any other `trig_mode` the pulse does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control write strobe |
| wr_en | input | 1 | Enable value written |
| wr_go | input | 1 | Start (1) / stop (0) value written |
| wr_src | input | 2 | Conversion clock source written; 2'b11 = RC |
| wr_ie | input | 1 | Interrupt enable written |
| wr_flag | input | 1 | Writing 0 clears the interrupt flag |
| trig_in | input | 1 | Compare-match event pulse |
| trig_mode | input | 4 | Mode of the compare unit; 4'b1011 = trigger |
| core_sleep | input | 1 | Core is asleep |
| rc_tick | input | 1 | One conversion period of the RC clock |
| cmp_in | input | 1 | Comparator: input >= trial code |
| trial_code | output | 10 | Code presented to the DAC/comparator |
| result | output | 10 | Last completed conversion result |
| go_busy | output | 1 | Conversion pending or running |
| enabled | output | 1 | Enable bit |
| int_flag | output | 1 | Conversion-complete interrupt flag |
| wake_req | output | 1 | Wake request pulse to the core |
| conv_powered | output | 1 | Converter powered up |
| timer_clear | output | 1 | Clear pulse for the companion timer |

## Verification
A write or trigger lands on one clock edge. `go_busy`, the abort effects and `timer_clear` show one edge later. Completion shows at 12 times the divider after the starting edge, or after 4 plus 12 edges for RC with a steady tick. The result, flag and wake pulse change on that same edge. The bench drives at falling edges and counts rising edges from the starting edge. It samples just before and just after the completion edge to pin the exact cycle. Runs with a random RC tick poll `go_busy` and then compare the result with the modelled input.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} conv_st_e;
  localparam logic [1:0] SRC_RC    = 2'b11;
  localparam logic [3:0] TRIG_MODE = 4'b1011;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV0 = 2,
  parameter int unsigned DIV1 = 8,
  parameter int unsigned DIV2 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] src,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int unsigned DMAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned DMAX   = (DMAX01 > DIV2) ? DMAX01 : DIV2;
  localparam int CW = $clog2(DMAX) + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (src)
      2'b00:   lim = CW'(DIV0 - 1);
      2'b01:   lim = CW'(DIV1 - 1);
      default: lim = CW'(DIV2 - 1);
    endcase
  end

  assign tick = run && ((src == SRC_RC) ? rc_tick : (cnt_q == lim));

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src != SRC_RC) |-> (cnt_q <= lim)) else $error("divider overran"); // R4
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int NBITS = 10,
  parameter int EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kill,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result,
  output logic             done
);
  localparam int STEPS = NBITS + EXTRA;
  localparam int SW    = $clog2(STEPS);

  logic [SW-1:0]    step_q, step_d;
  logic [NBITS-1:0] sar_q, sar_d, res_q;
  logic             last;

  assign last = (step_q == SW'(STEPS - 1));
  assign done = run && tick && last && !kill;

  always_comb begin
    step_d = step_q;
    sar_d  = sar_q;
    if (!run) begin
      step_d = '0;
      sar_d  = '0;
    end else if (tick) begin
      if (!last) step_d = step_q + 1'b1;
      for (int i = 0; i < NBITS; i++)
        if (step_q == SW'(NBITS - 1 - i)) sar_d[i] = cmp_in;
    end
  end

  for (genvar g = 0; g < NBITS; g++) begin : g_trial
    assign trial[g] = sar_q[g] | (run && (step_q == SW'(NBITS - 1 - g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      sar_q  <= '0;
    end else begin
      step_q <= step_d;
      sar_q  <= sar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (done) res_q <= sar_q;
  end

  assign result = res_q;

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, step_q} < (SW+1)'(STEPS))) else $error("step overran"); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q)) else $error("result moved without completion"); // R10
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int START_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       wr_en,
  input  logic       wr_go,
  input  logic [1:0] wr_src,
  input  logic       wr_ie,
  input  logic       wr_flag,
  input  logic       trig_in,
  input  logic [3:0] trig_mode,
  input  logic       core_sleep,
  input  logic       done,
  output logic       run,
  output logic       kill,
  output logic [1:0] src,
  output logic       go_busy,
  output logic       enabled,
  output logic       int_flag,
  output logic       wake_req,
  output logic       conv_powered,
  output logic       timer_clear
);
  localparam int DW = $clog2(START_DLY + 1);

  conv_st_e      st_q, st_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          en_q, en_d, ie_q, ie_d, flag_q, flag_d;
  logic          wake_q, wake_d, pwr_q, pwr_d, tclr_q, tclr_d;
  logic [1:0]    src_q, src_d;
  logic          busy, trig_hit, sleep_kill, start_ok;

  assign en_d  = reg_wr ? wr_en  : en_q;
  assign ie_d  = reg_wr ? wr_ie  : ie_q;
  assign src_d = reg_wr ? wr_src : src_q;

  assign busy       = (st_q != ST_IDLE);
  assign trig_hit   = trig_in && (trig_mode == TRIG_MODE);
  assign sleep_kill = core_sleep && (src_q != SRC_RC);
  assign kill       = busy && ((reg_wr && (!wr_go || !wr_en)) || sleep_kill);
  assign start_ok   = !busy && en_d && ((reg_wr && wr_go) || trig_hit)
                      && !(core_sleep && src_d != SRC_RC);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    case (st_q)
      ST_IDLE: if (start_ok) begin
        st_d  = (src_d == SRC_RC) ? ST_WAIT : ST_CONV;
        dly_d = '0;
      end
      ST_WAIT: begin
        if (kill)                            st_d = ST_IDLE;
        else if (dly_q == DW'(START_DLY - 1)) st_d = ST_CONV;
        else                                 dly_d = dly_q + 1'b1;
      end
      ST_CONV: if (kill || done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (reg_wr && !wr_flag) flag_d = 1'b0;
    if (done)               flag_d = 1'b1;
    wake_d = done && core_sleep && ie_q;
    tclr_d = trig_hit;
    pwr_d  = pwr_q;
    if (sleep_kill)                         pwr_d = 1'b0;
    else if (done && core_sleep && !ie_q)   pwr_d = 1'b0;
    else if (reg_wr)                        pwr_d = wr_en;
    else if (start_ok)                      pwr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dly_q  <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      src_q  <= 2'b00;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
      pwr_q  <= 1'b0;
      tclr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      en_q   <= en_d;
      ie_q   <= ie_d;
      src_q  <= src_d;
      flag_q <= flag_d;
      wake_q <= wake_d;
      pwr_q  <= pwr_d;
      tclr_q <= tclr_d;
    end
  end

  assign run          = (st_q == ST_CONV);
  assign src          = src_q;
  assign go_busy      = busy;
  assign enabled      = en_q;
  assign int_flag     = flag_q;
  assign wake_req     = wake_q;
  assign conv_powered = pwr_q;
  assign timer_clear  = tclr_q;

  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q) else $error("busy while disabled"); // R2
  AST_SLEEP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_sleep && src_q != SRC_RC) |=> (!busy && !pwr_q && en_q))
    else $error("sleep did not abort"); // R9
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flag_q && !busy)) else $error("completion lost"); // R6
  AST_WAKE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> flag_q) else $error("wake without flag"); // R8
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int          NBITS     = 10,
  parameter int          EXTRA     = 2,
  parameter int          START_DLY = 4,
  parameter int unsigned DIV0      = 2,
  parameter int unsigned DIV1      = 8,
  parameter int unsigned DIV2      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             wr_en,
  input  logic             wr_go,
  input  logic [1:0]       wr_src,
  input  logic             wr_ie,
  input  logic             wr_flag,
  input  logic             trig_in,
  input  logic [3:0]       trig_mode,
  input  logic             core_sleep,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial_code,
  output logic [NBITS-1:0] result,
  output logic             go_busy,
  output logic             enabled,
  output logic             int_flag,
  output logic             wake_req,
  output logic             conv_powered,
  output logic             timer_clear
);
  logic       rst_meta, rst_s;
  logic       run, kill, tick, done;
  logic [1:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  adc_seq_ctrl #(.START_DLY(START_DLY)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .reg_wr(reg_wr), .wr_en(wr_en), .wr_go(wr_go),
    .wr_src(wr_src), .wr_ie(wr_ie), .wr_flag(wr_flag), .trig_in(trig_in),
    .trig_mode(trig_mode), .core_sleep(core_sleep), .done(done), .run(run),
    .kill(kill), .src(src), .go_busy(go_busy), .enabled(enabled),
    .int_flag(int_flag), .wake_req(wake_req), .conv_powered(conv_powered),
    .timer_clear(timer_clear)
  );

  adc_tick_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tick (
    .clk(clk), .rst_n(rst_s), .run(run), .src(src), .rc_tick(rc_tick), .tick(tick)
  );

  adc_sar_core #(.NBITS(NBITS), .EXTRA(EXTRA)) u_sar (
    .clk(clk), .rst_n(rst_s), .run(run), .tick(tick), .kill(kill), .cmp_in(cmp_in),
    .trial(trial_code), .result(result), .done(done)
  );
endmodule

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, reg_wr, wr_en, wr_go, wr_ie, wr_flag, trig_in, core_sleep, rc_tick;
  logic [1:0] wr_src;
  logic [3:0] trig_mode;
  logic       cmp_in;
  logic [9:0] trial_code, result;
  logic       go_busy, enabled, int_flag, wake_req, conv_powered, timer_clear;
  logic [9:0] vin;
  bit         rc_rand;
  int         n_chk, n_err;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_in = (trial_code <= vin);

  adc_seq_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_en(wr_en), .wr_go(wr_go),
    .wr_src(wr_src), .wr_ie(wr_ie), .wr_flag(wr_flag), .trig_in(trig_in),
    .trig_mode(trig_mode), .core_sleep(core_sleep), .rc_tick(rc_tick),
    .cmp_in(cmp_in), .trial_code(trial_code), .result(result), .go_busy(go_busy),
    .enabled(enabled), .int_flag(int_flag), .wake_req(wake_req),
    .conv_powered(conv_powered), .timer_clear(timer_clear)
  );

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'b00) ? 2 : (s == 2'b01) ? 8 : 32;
  endfunction

  function automatic int conv_cycles(input logic [1:0] s);
    return (s == 2'b11) ? 4 + 12 : 12 * div_of(s);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit go, input logic [1:0] s, input bit ie, input bit fl);
    @(negedge clk);
    reg_wr = 1'b1; wr_en = en; wr_go = go; wr_src = s; wr_ie = ie; wr_flag = fl;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic trig(input logic [3:0] m);
    @(negedge clk);
    trig_mode = m; trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial forever begin
    @(negedge clk);
    rc_tick = rc_rand ? ($urandom % 3 == 0) : 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [9:0] prev;
    void'($urandom(32'd20240611));
    n_chk = 0; n_err = 0; rc_rand = 0;
    rst_n = 1'b0; reg_wr = 0; wr_en = 0; wr_go = 0; wr_src = 0; wr_ie = 0; wr_flag = 1;
    trig_in = 0; trig_mode = 4'b0000; core_sleep = 0; vin = 10'h000; rc_tick = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 go", go_busy, 0); chk("R1 en", enabled, 0); chk("R1 flag", int_flag, 0);
    chk("R1 wake", wake_req, 0); chk("R1 pwr", conv_powered, 0);
    chk("R1 tclr", timer_clear, 0); chk("R1 trial", trial_code, 0);

    // R2 go without enable
    wr(0, 1, 2'b00, 0, 1);
    chk("R2 no start when disabled", go_busy, 0);

    // R3 R4 R6 directed conversion, divide by 2
    vin = 10'h2A5;
    wr(1, 1, 2'b00, 0, 1);
    chk("R2 started", go_busy, 1);
    chk("R3 first trial", trial_code, 10'h200);
    repeat (2) @(negedge clk);
    chk("R3 second trial", trial_code, 10'h300 & ~10'h100 | 10'h100 & 10'h300 ? 10'h100 | (vin & 10'h200) : 0);
    repeat (12*2 - 3) @(negedge clk);
    chk("R4 busy before end div2", go_busy, 1);
    @(negedge clk);
    chk("R4 done at 24", go_busy, 0);
    chk("R6 result", result, vin);
    chk("R6 flag", int_flag, 1);

    // R7 flag clear only by writing 0
    wr(1, 0, 2'b00, 0, 1);
    chk("R7 write 1 keeps flag", int_flag, 1);
    wr(1, 0, 2'b00, 0, 0);
    chk("R7 write 0 clears flag", int_flag, 0);

    // R4 divide by 8 and 32
    for (int s = 1; s < 3; s++) begin
      vin = 10'(s * 300 + 7);
      wr(1, 1, 2'(s), 0, 1);
      repeat (conv_cycles(2'(s)) - 1) @(negedge clk);
      chk("R4 busy before end", go_busy, 1);
      @(negedge clk);
      chk("R4 done on time", go_busy, 0);
      chk("R3 result", result, vin);
    end

    // R10 software abort
    prev = result; vin = 10'h0F0;
    wr(1, 1, 2'b01, 0, 1);
    repeat (10) @(negedge clk);
    wr(1, 0, 2'b01, 0, 1);
    chk("R10 aborted", go_busy, 0);
    repeat (120) @(negedge clk);
    chk("R10 result kept", result, prev);

    // R9 sleep abort with divided source
    wr(1, 1, 2'b10, 0, 1);
    repeat (20) @(negedge clk);
    core_sleep = 1'b1;
    @(negedge clk);
    chk("R9 aborted", go_busy, 0); chk("R9 unpowered", conv_powered, 0);
    chk("R9 en kept", enabled, 1); chk("R9 result kept", result, prev);
    core_sleep = 1'b0;

    // R5 R8 RC through sleep, interrupt enabled
    wr(1, 0, 2'b11, 1, 0);
    vin = 10'h3C1;
    wr(1, 1, 2'b11, 1, 1);
    core_sleep = 1'b1;
    repeat (conv_cycles(2'b11) - 1) @(negedge clk);
    chk("R5 busy before end", go_busy, 1);
    @(negedge clk);
    chk("R5 done at 16", go_busy, 0);
    chk("R8 wake", wake_req, 1); chk("R5 result", result, vin);
    chk("R8 powered", conv_powered, 1);
    @(negedge clk);
    chk("R8 wake pulse ends", wake_req, 0);
    core_sleep = 1'b0;

    // R8 RC through sleep, interrupt disabled
    vin = 10'h011;
    wr(1, 1, 2'b11, 0, 0);
    core_sleep = 1'b1;
    repeat (conv_cycles(2'b11)) @(negedge clk);
    chk("R8 no wake", wake_req, 0); chk("R8 powered down", conv_powered, 0);
    chk("R8 en kept", enabled, 1); chk("R7 flag without ie", int_flag, 1);
    chk("R8 result", result, vin);
    core_sleep = 1'b0;

    // R11 trigger handling
    wr(0, 0, 2'b00, 0, 0);
    trig(4'b1011);
    chk("R11 disabled ignores start", go_busy, 0);
    chk("R11 timer clear when disabled", timer_clear, 1);
    @(negedge clk);
    chk("R11 clear is one cycle", timer_clear, 0);
    wr(1, 0, 2'b00, 0, 1);
    trig(4'b1010);
    chk("R11 wrong mode no start", go_busy, 0);
    chk("R11 wrong mode no clear", timer_clear, 0);
    vin = 10'h155;
    trig(4'b1011);
    chk("R11 trigger starts", go_busy, 1);
    chk("R11 trigger clears timer", timer_clear, 1);
    repeat (conv_cycles(2'b00) - 1) @(negedge clk);
    @(negedge clk);
    chk("R11 trig result", result, vin);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] s;
      int n;
      s = 2'($urandom % 4);
      vin = 10'($urandom % 1024);
      rc_rand = (s == 2'b11);
      if ($urandom % 2 == 0) wr(1, 1, s, 0, 1);
      else begin
        wr(1, 0, s, 0, 1);
        trig(4'b1011);
      end
      if (s != 2'b11) begin
        repeat (conv_cycles(s) - 1) @(negedge clk);
        chk("R4 random busy", go_busy, 1);
        @(negedge clk);
        chk("R4 random done", go_busy, 0);
      end else begin
        n = 0;
        while (go_busy && n < 2000) begin @(negedge clk); n++; end
        chk("R5 random finished", go_busy, 0);
      end
      chk("R3 random result", result, vin);
      chk("R6 random flag", int_flag, 1);
      rc_rand = 0;
    end

    finish_run();
  end
endmodule